// File: doc/BRIEF.md
# Run-Time Format-Selectable Array Multiplier

This block is a purely combinational N×N parallel array multiplier. The default is N = 3. Its cells sit in N rows. Each row forms N partial-product bits, adds them to the running partial sum carried down from the row above, and hands its least significant sum bit to the product. A two-bit format code, which can change from one operation to the next, chooses the operand encoding: unsigned, sign plus magnitude, or two's complement. Two's complement is handled by flipping the partial products that involve exactly one sign bit and adding two correction constants, so the operands never need sign extension.

The array exposes carry and sum taps so that a neighbouring module can feed it intermediate values:
- A multiplexer on the partial-sum input replaces the array's own starting sum with an external word.
- A multiplexer on each row's carry input chooses between the internal carry and an external bit.
- The carry out of every row is brought out on a port.

With all selects low, the module works alone as a complete multiplier.

Top module: `cfg_array_mult`

## Requirements
- R1: The format code `fmt` selects the encoding: 2'b00 unsigned, 2'b01 sign-magnitude, 2'b10 two's complement. The reserved code 2'b11 gives exactly the unsigned result.
- R2: In unsigned mode with every external select low, `prod` equals a·b for every operand pair, as a 2N-bit value.
- R3: In two's complement mode with the external selects low, `prod` is the 2N-bit two's complement encoding of the signed product of the operands.
- R4: In sign-magnitude mode, bit N-1 of each operand is its sign and bits N-2..0 are its magnitude. `prod[2N-2:0]` is the product of the magnitudes. `prod[2N-1]` is the XOR of the two sign bits.
- R5: In sign-magnitude mode, when either magnitude is zero the whole product is zero, with a positive sign.
- R6: When `psum_sel` is high, the array's internal starting partial sum is replaced by `psum_ext`, added at weight 2^0. In unsigned mode this gives `prod` = a·b + `psum_ext`.
- R7: When `cin_sel[i]` is high, row i takes `cin_ext[i]` as its carry input, added at weight 2^i, in place of its internal carry.
- R8: `row_cout[i]` is bit i+N of the running total after row i. The running total is the starting partial sum plus, for each row k ≤ i, the row's partial-product word and carry input, both weighted by 2^k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | Multiplicand |
| b_in | input | N | Multiplier |
| fmt | input | 2 | Operand format code |
| psum_sel | input | 1 | Use the external starting partial sum |
| psum_ext | input | N | External starting partial sum |
| cin_sel | input | N | Per-row select of the external carry input |
| cin_ext | input | N | External per-row carry inputs |
| prod | output | 2N | Product |
| row_cout | output | N | Carry out of each row |

## Verification
The bench builds the block with N = 3. At that size every one of the 64 operand pairs can be applied in each of the four format codes, so every sign combination and every zero-magnitude case is reached, including the most negative two's complement operands. Carry and sum injection is then exercised in unsigned mode over all operand pairs, with injected values that vary with the operands. The row carry outputs are compared against a running integer sum that the bench computes itself.

// File: rtl/cfg_array_mult.sv
module cfg_array_mult #(
  parameter int N = 3
) (
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  input  logic [1:0]     fmt,
  input  logic           psum_sel,
  input  logic [N-1:0]   psum_ext,
  input  logic [N-1:0]   cin_sel,
  input  logic [N-1:0]   cin_ext,
  output logic [2*N-1:0] prod,
  output logic [N-1:0]   row_cout
);
  localparam int W = 2 * N;

  logic is_sm, is_tc;
  assign is_sm = (fmt == 2'b01);
  assign is_tc = (fmt == 2'b10);

  logic [N-1:0] a_op, b_op;
  assign a_op = is_sm ? {1'b0, a_in[N-2:0]} : a_in;
  assign b_op = is_sm ? {1'b0, b_in[N-2:0]} : b_in;

  // two's complement correction: 2^(N-1) twice (start sum and top-row carry) = 2^N
  logic [N-1:0] corr, cin_eff;
  assign corr    = {is_tc, {(N-1){1'b0}}};
  assign cin_eff = (cin_sel & cin_ext) | (~cin_sel & corr);

  logic [N:0][N-1:0] prev;
  logic [N-1:0][N:0] rsum;
  logic [N-1:0]      lo;

  assign prev[0] = psum_sel ? psum_ext : corr;

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [N-1:0] pp;
    for (genvar j = 0; j < N; j++) begin : g_cell
      localparam bit SPECIAL = ((i == N-1) != (j == N-1));
      if (SPECIAL) begin : g_inv
        assign pp[j] = (a_op[j] & b_op[i]) ^ is_tc;
      end else begin : g_pass
        assign pp[j] = a_op[j] & b_op[i];
      end
    end
    assign rsum[i]     = {1'b0, prev[i]} + {1'b0, pp} + (N+1)'(cin_eff[i]);
    assign lo[i]       = rsum[i][0];
    assign prev[i+1]   = rsum[i][N:1];
    assign row_cout[i] = rsum[i][N];
  end

  logic [W-1:0] raw;
  logic         sm_sign;
  assign raw     = {prev[N], lo};
  assign sm_sign = (a_in[N-1] ^ b_in[N-1]) & (|a_in[N-2:0]) & (|b_in[N-2:0]);
  assign prod    = is_sm ? {sm_sign, raw[W-2:0]} : {raw[W-1] ^ is_tc, raw[W-2:0]};

  logic [W-1:0] chk_sa, chk_sb, chk_inj, chk_mag;
  logic         chk_idle;
  always_comb begin
    chk_sa   = {{N{a_in[N-1]}}, a_in};
    chk_sb   = {{N{b_in[N-1]}}, b_in};
    chk_mag  = W'(a_in[N-2:0]) * W'(b_in[N-2:0]);
    chk_idle = !psum_sel && (cin_sel == '0);
    chk_inj  = psum_sel ? W'(psum_ext) : '0;
    for (int k = 0; k < N; k++) begin
      chk_inj = chk_inj + (W'(cin_sel[k] & cin_ext[k]) << k);
    end
    if (!is_sm && !is_tc) begin
      AST_UNSIGNED_EXACT: assert (prod == W'(a_in) * W'(b_in) + chk_inj); // R2
    end
    if (is_tc && chk_idle) begin
      AST_TWOS_COMP_EXACT: assert (prod == W'(chk_sa * chk_sb)); // R3
    end
    if (is_sm && chk_idle) begin
      AST_SM_MAGNITUDE: assert (prod[W-2:0] == chk_mag); // R4
      AST_SM_POS_ZERO: assert ((prod[W-2:0] != '0) || !prod[W-1]); // R5
    end
  end
endmodule

// File: tb/cfg_array_mult_test.sv
module cfg_array_mult_test;
  localparam int N = 3;
  localparam int W = 2 * N;
  localparam int CLK_PERIOD = 10;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0] a_in = '0, b_in = '0, psum_ext = '0, cin_sel = '0, cin_ext = '0;
  logic [1:0]   fmt = 2'b00;
  logic         psum_sel = 1'b0;
  logic [W-1:0] prod;
  logic [N-1:0] row_cout;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  cfg_array_mult #(.N(N)) uut (
    .a_in(a_in), .b_in(b_in), .fmt(fmt), .psum_sel(psum_sel), .psum_ext(psum_ext),
    .cin_sel(cin_sel), .cin_ext(cin_ext), .prod(prod), .row_cout(row_cout)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d fmt=%0d actual=%0d expected=%0d", req, a_in, b_in, fmt, act, exp);
    end
  endtask

  task automatic apply(input int f, input int a, input int b, input bit ps, input int pe,
                       input int cs, input int ce);
    @(posedge clk);
    fmt = 2'(f); a_in = N'(a); b_in = N'(b);
    psum_sel = ps; psum_ext = N'(pe); cin_sel = N'(cs); cin_ext = N'(ce);
    @(negedge clk);
  endtask

  function automatic longint sval(input int v);
    return (v >= (1 << (N-1))) ? longint'(v) - (64'd1 << N) : longint'(v);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint exp_v, run, cexp;
    int ma, mb, sgn, cs, ce, pe;
    apply(0, 0, 0, 0, 0, 0, 0);
    check("R2 zero inputs", prod, 0);

    for (int f = 0; f < 4; f++) begin
      for (int a = 0; a < (1 << N); a++) begin
        for (int b = 0; b < (1 << N); b++) begin
          apply(f, a, b, 0, 0, 0, 0);
          if (f == 1) begin
            ma = a & ((1 << (N-1)) - 1);
            mb = b & ((1 << (N-1)) - 1);
            sgn = ((a >> (N-1)) ^ (b >> (N-1))) & 1;
            if (ma == 0 || mb == 0) check("R5 sm zero", prod, 0);
            else begin
              check("R4 sm magnitude", prod[W-2:0], ma * mb);
              check("R4 sm sign", prod[W-1], sgn);
            end
          end else if (f == 2) begin
            exp_v = (sval(a) * sval(b)) & MASK;
            check("R3 twos complement", prod, exp_v);
          end else if (f == 3) begin
            check("R1 reserved as unsigned", prod, a * b);
          end else begin
            check("R2 unsigned", prod, a * b);
          end
        end
      end
    end

    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        pe = (a + 2 * b + 1) % (1 << N);
        apply(0, a, b, 1, pe, 0, 0);
        check("R6 psum inject", prod, a * b + pe);

        cs = (a ^ b) | 1;
        ce = (3 * a + b + 5) % (1 << N);
        apply(0, a, b, 0, 0, cs, ce);
        exp_v = a * b;
        for (int i = 0; i < N; i++)
          if (((cs >> i) & 1) != 0) exp_v += longint'((ce >> i) & 1) << i;
        check("R7 carry inject", prod, exp_v);

        apply(3, a, b, 1, pe, (1 << N) - 1, ce);
        run = pe;
        cexp = 0;
        for (int i = 0; i < N; i++) begin
          run += (((b >> i) & 1) != 0) ? (longint'(a) << i) : 0;
          run += longint'((ce >> i) & 1) << i;
          cexp |= ((run >> (i + N)) & 1) << i;
        end
        check("R8 row carry out", row_cout, cexp);
        check("R1 R6 R7 reserved code with injection", prod, run & MASK);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule